// File: doc/BRIEF.md
# Asynchronous USART with Ninth-Bit Attention

A full-duplex asynchronous serial transmitter and receiver sits behind a small register port. The data portion of a frame can be 7, 8 or 9 bits long. In 9-bit frames the transmitted top bit comes from a control bit, and the received top bit is kept in the status register. An optional parity bit can follow the data, and the transmitter sends one or two stop bits. The receiver oversamples the line at 16 times the bit rate and reports framing, parity and overrun errors. A two-stage counter chain divides the system clock down to the oversampling tick.

For multiprocessor links, an attention mode drops every received frame whose ninth bit is 0. A frame with ninth bit 1 is taken as an address frame and is accepted. Attention mode stays on until software turns it off.

Registers sit at `addr_i`: 0 transmit data (write), 1 receive data (read), 2 frame control, 3 receive status, 4 interrupt control, 5 prescaler, 6 divisor. Writes take effect on the clock edge with `wr_en_i` high. `rdata_o` shows the addressed register combinationally. A read strobe (`rd_en_i`) on address 1 consumes the received byte.

Top module: `usart_attn`

## Requirements
- R1: A transmit frame is a 0 start bit, then the data bits LSB first, then any ninth bit and parity bit, then stop bits at 1. Frame control bits [1:0] select 7 (0), 9 (2) or 8 (1 or 3) data bits. The line idles at 1.
- R2: In 9-bit frames the transmitter sends frame control bit [2] as the ninth data bit.
- R3: After a 9-bit frame is accepted, its ninth bit appears in status bit [4]. After a 7- or 8-bit frame, status bit [4] is 0.
- R4: When frame control bit [3] is set, a parity bit follows the data and any ninth bit. The parity bit is the XOR of those bits, inverted when frame control bit [4] is set (odd parity).
- R5: When parity is enabled and a received parity bit disagrees, status bit [3] sets. It stays set until a 1 is written to it.
- R6: When the first stop bit is sampled as 0, status bit [1] sets. It is cleared by writing 1 to it.
- R7: When a frame is accepted while status bit [0] (receive ready) is still set, status bit [2] (overrun) sets and the new byte replaces the old one. Writing 1 clears the overrun bit.
- R8: With frame control bit [5] set, the transmitter sends two stop bits. Otherwise it sends one. The receiver checks only the first stop bit.
- R9: `tx_irq_o` equals interrupt control bit [0] AND an empty transmit buffer. Bit [2] of that register reads back the empty state. `rx_irq_o` equals interrupt control bit [1] AND receive ready. Reading address 1 clears receive ready.
- R10: Status bit [6] is 1 while a reception is in progress. Status bit [7] is 1 while a transmission is in progress.
- R11: With status bit [5] (attention) set, a received frame whose ninth bit is 0 changes neither the receive buffer nor any status flag. A frame with ninth bit 1 is accepted and leaves attention set.
- R12: One bit lasts 16 x (P+1) x (D+1) clock cycles, where P is the prescaler register and D is the divisor register.
- R13: After reset every register reads 0, except that interrupt control reads 0x04 (buffer empty). `txd_o` is 1 and both interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effect on address 1) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| tx_irq_o | output | 1 | Transmit buffer empty interrupt |
| rx_irq_o | output | 1 | Receive ready interrupt |

## Verification
Register writes are visible one edge after the strobe, and reads are sampled in the strobe cycle itself. A transmitted frame starts on the edge after the data write when the line is idle. The bench finds the start edge on the line and then samples each bit half a bit period later at its centre, using the bit length from R12. Receive flags are set about half a bit plus two synchroniser cycles after the stop bit starts. The receive driver therefore holds the line idle for a whole bit before the status is read. A bad stop bit is driven just past its centre, so that no false start follows.

// File: rtl/usart_pkg.sv
package usart_pkg;
  localparam int FRAME_W = 13;

  localparam logic [2:0] A_TXD  = 3'd0;
  localparam logic [2:0] A_RXD  = 3'd1;
  localparam logic [2:0] A_FRM  = 3'd2;
  localparam logic [2:0] A_STAT = 3'd3;
  localparam logic [2:0] A_IRQ  = 3'd4;
  localparam logic [2:0] A_PSC  = 3'd5;
  localparam logic [2:0] A_DIV  = 3'd6;

  typedef struct packed {
    logic       two_stop;
    logic       par_odd;
    logic       par_en;
    logic       tx_b8;
    logic [1:0] len;
  } frame_cfg_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_state_e;

  function automatic logic [3:0] data_bits(input logic [1:0] len);
    case (len)
      2'd0:    data_bits = 4'd7;
      2'd2:    data_bits = 4'd9;
      default: data_bits = 4'd8;
    endcase
  endfunction

  function automatic logic [8:0] data_mask(input logic [1:0] len);
    case (len)
      2'd0:    data_mask = 9'h07f;
      2'd2:    data_mask = 9'h1ff;
      default: data_mask = 9'h0ff;
    endcase
  endfunction
endpackage

// File: rtl/usart_baud.sv
module usart_baud #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] psc_i,
  input  logic [CNT_W-1:0] div_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] psc_cnt_q, div_cnt_q;
  logic psc_wrap, div_wrap;

  assign psc_wrap = (psc_cnt_q >= psc_i);
  assign div_wrap = (div_cnt_q >= div_i);
  assign tick_o   = psc_wrap && div_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_cnt_q <= '0;
      div_cnt_q <= '0;
    end else if (psc_wrap) begin
      psc_cnt_q <= '0;
      if (div_wrap) div_cnt_q <= '0;
      else          div_cnt_q <= div_cnt_q + 1'b1;
    end else begin
      psc_cnt_q <= psc_cnt_q + 1'b1;
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && (psc_i != '0 || div_i != '0)) |=>
      (!tick_o || !$stable(psc_i) || !$stable(div_i))); // R12
endmodule

// File: rtl/usart_tx.sv
module usart_tx import usart_pkg::*; #(
  parameter int OSR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  frame_cfg_t cfg_i,
  input  logic       load_i,
  input  logic [7:0] data_i,
  output logic       take_o,
  output logic       busy_o,
  output logic       txd_o
);
  localparam int PH_W   = $clog2(OSR);
  localparam int LEFT_W = $clog2(FRAME_W + 1);

  logic               busy_q;
  logic [FRAME_W-1:0] sh_q, frame_d;
  logic [PH_W-1:0]    ph_q;
  logic [LEFT_W-1:0]  left_q, len_d;
  logic [8:0]         d9;
  logic [3:0]         nd;
  int                 pos;

  always_comb begin
    d9      = {cfg_i.tx_b8, data_i} & data_mask(cfg_i.len);
    nd      = data_bits(cfg_i.len);
    frame_d = '1;
    frame_d[0] = 1'b0;
    for (int i = 0; i < 9; i++) begin
      if (i < int'(nd)) frame_d[1+i] = d9[i];
    end
    pos = 1 + int'(nd);
    if (cfg_i.par_en) begin
      frame_d[pos] = (^d9) ^ cfg_i.par_odd;
      pos = pos + 1;
    end
    pos   = pos + (cfg_i.two_stop ? 2 : 1);
    len_d = LEFT_W'(pos);
  end

  assign take_o = !busy_q && load_i;
  assign busy_o = busy_q;
  assign txd_o  = busy_q ? sh_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      ph_q   <= '0;
      left_q <= '0;
    end else if (take_o) begin
      sh_q   <= frame_d;
      left_q <= len_d;
      ph_q   <= '0;
      busy_q <= 1'b1;
    end else if (busy_q && tick_i) begin
      if (ph_q == PH_W'(OSR - 1)) begin
        ph_q   <= '0;
        sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
        left_q <= left_q - 1'b1;
        if (left_q == LEFT_W'(1)) busy_q <= 1'b0;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  AST_TX_START_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !txd_o); // R1
endmodule

// File: rtl/usart_rx.sv
module usart_rx import usart_pkg::*; #(
  parameter int OSR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] len_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic       rxd_i,
  output logic       done_o,
  output logic [7:0] data_o,
  output logic       b8_o,
  output logic       perr_o,
  output logic       ferr_o,
  output logic       busy_o
);
  localparam int PH_W = $clog2(OSR);

  rx_state_e       state_q;
  logic            rx_s1_q, rx_s2_q;
  logic [PH_W-1:0] ph_q;
  logic [3:0]      idx_q, nd, nbits;
  logic [9:0]      bits_q;
  logic [8:0]      d9;
  logic            par_bad, done_q;

  assign nd      = data_bits(len_i);
  assign nbits   = nd + {3'b0, par_en_i};
  assign d9      = bits_q[8:0] & data_mask(len_i);
  assign par_bad = (^d9) ^ par_odd_i ^ bits_q[nd];
  assign busy_o  = (state_q != RX_IDLE);
  assign done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_s1_q <= 1'b1;
      rx_s2_q <= 1'b1;
    end else begin
      rx_s1_q <= rxd_i;
      rx_s2_q <= rx_s1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      ph_q    <= '0;
      idx_q   <= '0;
      bits_q  <= '0;
      done_q  <= 1'b0;
      data_o  <= '0;
      b8_o    <= 1'b0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) begin
        case (state_q)
          RX_IDLE: if (!rx_s2_q) begin
            state_q <= RX_START;
            ph_q    <= '0;
          end
          RX_START: if (ph_q == PH_W'(OSR/2 - 1)) begin
            ph_q    <= '0;
            idx_q   <= '0;
            state_q <= rx_s2_q ? RX_IDLE : RX_BITS;  // glitch filter at mid start bit
          end else ph_q <= ph_q + 1'b1;
          RX_BITS: if (ph_q == PH_W'(OSR - 1)) begin
            ph_q          <= '0;
            bits_q[idx_q] <= rx_s2_q;
            if (idx_q == nbits - 4'd1) state_q <= RX_STOP;
            else                       idx_q   <= idx_q + 4'd1;
          end else ph_q <= ph_q + 1'b1;
          RX_STOP: if (ph_q == PH_W'(OSR - 1)) begin
            ph_q    <= '0;
            state_q <= RX_IDLE;
            done_q  <= 1'b1;
            ferr_o  <= !rx_s2_q;
            data_o  <= d9[7:0];
            b8_o    <= d9[8];
            perr_o  <= par_en_i && par_bad;
          end else ph_q <= ph_q + 1'b1;
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  AST_RX_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
endmodule

// File: rtl/usart_attn.sv
module usart_attn import usart_pkg::*; #(
  parameter int OSR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       rxd_i,
  output logic       txd_o,
  output logic       tx_irq_o,
  output logic       rx_irq_o
);
  localparam int BAUD_W = 8;

  frame_cfg_t        cfg_q;
  logic [7:0]        tbuf_q, rbuf_q;
  logic              tfull_q, rx_ready_q, ferr_q, ovr_q, perr_q, rb8_q, attn_q;
  logic              tx_ie_q, rx_ie_q;
  logic [BAUD_W-1:0] psc_q, div_q;

  logic       tick, tx_take, tx_busy, rx_busy;
  logic       rx_done, rx_b8, rx_perr, rx_ferr, rx_accept, rd_rx;
  logic [7:0] rx_data;

  usart_baud #(.CNT_W(BAUD_W)) u_baud (
    .clk_i, .rst_ni, .psc_i(psc_q), .div_i(div_q), .tick_o(tick)
  );

  usart_tx #(.OSR(OSR)) u_tx (
    .clk_i, .rst_ni, .tick_i(tick), .cfg_i(cfg_q), .load_i(tfull_q),
    .data_i(tbuf_q), .take_o(tx_take), .busy_o(tx_busy), .txd_o
  );

  usart_rx #(.OSR(OSR)) u_rx (
    .clk_i, .rst_ni, .tick_i(tick), .len_i(cfg_q.len), .par_en_i(cfg_q.par_en),
    .par_odd_i(cfg_q.par_odd), .rxd_i, .done_o(rx_done), .data_o(rx_data),
    .b8_o(rx_b8), .perr_o(rx_perr), .ferr_o(rx_ferr), .busy_o(rx_busy)
  );

  assign rd_rx     = rd_en_i && (addr_i == A_RXD);
  assign rx_accept = rx_done && !(attn_q && !rx_b8);
  assign tx_irq_o  = tx_ie_q && !tfull_q;
  assign rx_irq_o  = rx_ie_q && rx_ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      tbuf_q  <= '0;
      tfull_q <= 1'b0;
      tx_ie_q <= 1'b0;
      rx_ie_q <= 1'b0;
      psc_q   <= '0;
      div_q   <= '0;
    end else begin
      if (wr_en_i && addr_i == A_TXD) begin
        tbuf_q  <= wdata_i;
        tfull_q <= 1'b1;
      end else if (tx_take) begin
        tfull_q <= 1'b0;
      end
      if (wr_en_i) begin
        case (addr_i)
          A_FRM: cfg_q <= wdata_i[5:0];
          A_IRQ: {rx_ie_q, tx_ie_q} <= wdata_i[1:0];
          A_PSC: psc_q <= wdata_i;
          A_DIV: div_q <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbuf_q     <= '0;
      rx_ready_q <= 1'b0;
      ferr_q     <= 1'b0;
      ovr_q      <= 1'b0;
      perr_q     <= 1'b0;
      rb8_q      <= 1'b0;
      attn_q     <= 1'b0;
    end else begin
      if (wr_en_i && addr_i == A_STAT) begin
        attn_q <= wdata_i[5];
        if (wdata_i[1]) ferr_q <= 1'b0;
        if (wdata_i[2]) ovr_q  <= 1'b0;
        if (wdata_i[3]) perr_q <= 1'b0;
      end
      if (rx_accept) begin
        rbuf_q     <= rx_data;
        rb8_q      <= rx_b8;
        rx_ready_q <= 1'b1;
        if (rx_ready_q && !rd_rx) ovr_q <= 1'b1;
        if (rx_ferr) ferr_q <= 1'b1;
        if (rx_perr) perr_q <= 1'b1;
      end else if (rd_rx) begin
        rx_ready_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (addr_i)
      A_RXD:   rdata_o = rbuf_q;
      A_FRM:   rdata_o = {2'b00, cfg_q};
      A_STAT:  rdata_o = {tx_busy, rx_busy, attn_q, rb8_q, perr_q, ovr_q, ferr_q, rx_ready_q};
      A_IRQ:   rdata_o = {5'b0, !tfull_q, rx_ie_q, tx_ie_q};
      A_PSC:   rdata_o = psc_q;
      A_DIV:   rdata_o = div_q;
      default: rdata_o = '0;
    endcase
  end

  AST_OVR_AFTER_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_q) |-> $past(rx_ready_q)); // R7
  AST_ATTN_DISCARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && attn_q && !rx_b8) |=> $stable(rbuf_q)); // R11
endmodule

// File: tb/usart_attn_tb.sv
module usart_attn_tb_top;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 1'b0, rd_en_i = 1'b0, rxd_i = 1'b1;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic txd_o, tx_irq_o, rx_irq_o;

  always #5 clk = ~clk;

  usart_attn dut_i (
    .clk_i(clk), .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i, .rdata_o,
    .rxd_i, .txd_o, .tx_irq_o, .rx_irq_o
  );

  int total = 0, bad = 0;
  bit fin = 1'b0;
  int b_nd = 8, b_bitclk = 16;
  bit b_b8 = 0, b_pe = 0, b_po = 0, b_two = 0;
  string tx_tag = "R1";
  logic [15:0] txq_v[$];
  int          txq_n[$];
  logic [7:0]  rxq[$];
  logic [7:0]  last_rx = 8'h00;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  function automatic int build(input logic [8:0] d, output logic [15:0] v);
    int n;
    logic [8:0] m;
    m = (b_nd == 7) ? 9'h07f : (b_nd == 8) ? 9'h0ff : 9'h1ff;
    v = '1; v[0] = 1'b0; n = 1;
    for (int i = 0; i < b_nd; i++) begin v[n] = d[i]; n++; end
    if (b_pe) begin v[n] = (^(d & m)) ^ b_po; n++; end
    v[n] = 1'b1; n++;
    if (b_two) begin v[n] = 1'b1; n++; end
    return n;
  endfunction

  task automatic set_frame(input int nd, input bit b8, input bit pe, input bit po, input bit two);
    logic [1:0] lf;
    b_nd = nd; b_b8 = b8; b_pe = pe; b_po = po; b_two = two;
    lf = (nd == 7) ? 2'd0 : (nd == 9) ? 2'd2 : 2'd1;
    wr(3'd2, {2'b00, two, po, pe, b8, lf});
  endtask

  task automatic send_tx(input logic [7:0] d);
    logic [15:0] v;
    int n;
    n = build({b_b8, d}, v);
    txq_v.push_back(v);
    txq_n.push_back(n);
    wr(3'd0, d);
  endtask

  task automatic wait_tx();
    logic [7:0] s;
    s = 8'h80;
    while (txq_n.size() != 0 || s[7]) begin
      repeat (4) @(negedge clk);
      rd(3'd3, s);
    end
    repeat (b_bitclk) @(negedge clk);
  endtask

  // line monitor: pops the expected frame and compares bit by bit at the centre
  initial begin : tx_mon
    logic [15:0] got, ev, m;
    int n;
    forever begin
      @(negedge txd_o);
      repeat (b_bitclk / 2) @(negedge clk);
      if (txq_n.size() == 0) begin
        chk(tx_tag, "unexpected tx frame", 32'd1, 32'd0);
        continue;
      end
      ev = txq_v.pop_front();
      n  = txq_n.pop_front();
      got = '1;
      got[0] = txd_o;
      for (int i = 1; i < n; i++) begin
        repeat (b_bitclk) @(negedge clk);
        got[i] = txd_o;
      end
      m = (16'h1 << n) - 16'h1;
      chk(tx_tag, "tx frame bits", {16'h0, got & m}, {16'h0, ev & m});
    end
  end

  task automatic send_rx(input logic [8:0] d, input bit accept, input bit bad_par, input bit bad_stop);
    logic [15:0] v;
    int n, s;
    n = build(d, v);
    s = 1 + b_nd + (b_pe ? 1 : 0);
    if (bad_par) v[s-1] = ~v[s-1];
    if (accept) rxq.push_back(d[7:0]);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxd_i = v[i];
      if (bad_stop && i == s) begin
        rxd_i = 1'b0;
        repeat (b_bitclk / 2 + 4) @(negedge clk);
        rxd_i = 1'b1;
        repeat (b_bitclk / 2 - 5) @(negedge clk);
      end else begin
        repeat (b_bitclk - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    rxd_i = 1'b1;
    repeat (b_bitclk) @(negedge clk);
  endtask

  task automatic rx_check(input string req, input logic [7:0] exp_stat);
    logic [7:0] s, d, e;
    if (rxq.size() != 0) begin
      while (rxq.size() > 1) void'(rxq.pop_front());
      e = rxq.pop_front();
      last_rx = e;
    end else begin
      e = last_rx;
    end
    rd(3'd3, s);
    chk(req, "rx status", {24'h0, s}, {24'h0, exp_stat});
    rd(3'd1, d);
    chk(req, "rx data", {24'h0, d}, {24'h0, e});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] r;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R13 reset state
    rd(3'd3, r); chk("R13", "status after reset", {24'h0, r}, 32'h00);
    rd(3'd4, r); chk("R13", "irq reg after reset", {24'h0, r}, 32'h04);
    rd(3'd2, r); chk("R13", "frame reg after reset", {24'h0, r}, 32'h00);
    chk("R13", "txd idle", {31'h0, txd_o}, 32'h1);
    chk("R13", "irqs idle", {30'h0, tx_irq_o, rx_irq_o}, 32'h0);

    // R1 8-bit frame, R10 tx busy
    tx_tag = "R1";
    set_frame(8, 0, 0, 0, 0);
    send_tx(8'ha5);
    repeat (5) @(negedge clk);
    rd(3'd3, r); chk("R10", "tx busy flag", {31'h0, r[7]}, 32'h1);
    wait_tx();

    // R1/R4 7-bit even parity
    tx_tag = "R4";
    set_frame(7, 0, 1, 0, 0);
    send_tx(8'h53);
    wait_tx();

    // R2 9-bit with ninth bit 1, odd parity
    tx_tag = "R2";
    set_frame(9, 1, 1, 1, 0);
    send_tx(8'h5a);
    wait_tx();

    // R8 two stop bits back to back, R9 tx interrupt
    tx_tag = "R8";
    wr(3'd4, 8'h01);
    chk("R9", "tx_irq with empty buffer", {31'h0, tx_irq_o}, 32'h1);
    set_frame(8, 0, 0, 0, 1);
    send_tx(8'h81);
    send_tx(8'h7e);
    chk("R9", "tx_irq with full buffer", {31'h0, tx_irq_o}, 32'h0);
    wait_tx();
    chk("R9", "tx_irq after drain", {31'h0, tx_irq_o}, 32'h1);

    // R12 baud: P=1, D=2 -> 96 clocks per bit
    tx_tag = "R12";
    wr(3'd5, 8'd1);
    wr(3'd6, 8'd2);
    b_bitclk = 96;
    set_frame(8, 0, 0, 0, 0);
    send_tx(8'hc3);
    wait_tx();
    wr(3'd5, 8'd0);
    wr(3'd6, 8'd0);
    b_bitclk = 16;

    // receive path, R9 rx interrupt, R10 rx busy
    wr(3'd4, 8'h02);
    fork
      send_rx(9'h03c, 1, 0, 0);
      begin
        repeat (60) @(negedge clk);
        rd(3'd3, r); chk("R10", "rx busy flag", {31'h0, r[6]}, 32'h1);
      end
    join
    chk("R9", "rx_irq on ready", {31'h0, rx_irq_o}, 32'h1);
    rx_check("R1", 8'h01);
    chk("R9", "rx_irq after read", {31'h0, rx_irq_o}, 32'h0);

    // R3 ninth bit saved
    set_frame(9, 0, 0, 0, 0);
    send_rx(9'h1a5, 1, 0, 0);
    rx_check("R3", 8'h11);

    // R5 parity error, then R4 good odd parity
    set_frame(8, 0, 1, 0, 0);
    send_rx(9'h00f, 1, 1, 0);
    rx_check("R5", 8'h09);
    wr(3'd3, 8'h0e);
    set_frame(8, 0, 1, 1, 0);
    send_rx(9'h001, 1, 0, 0);
    rx_check("R4", 8'h01);

    // R6 framing error
    set_frame(8, 0, 0, 0, 0);
    send_rx(9'h055, 1, 0, 1);
    rx_check("R6", 8'h03);
    wr(3'd3, 8'h0e);

    // R7 overrun
    send_rx(9'h011, 1, 0, 0);
    send_rx(9'h022, 1, 0, 0);
    rx_check("R7", 8'h05);
    wr(3'd3, 8'h0e);
    rd(3'd3, r); chk("R7", "overrun cleared", {24'h0, r}, 32'h00);

    // R11 attention: address-less frame dropped, address frame kept
    set_frame(9, 0, 0, 0, 0);
    wr(3'd3, 8'h20);
    send_rx(9'h011, 0, 0, 0);
    rx_check("R11", 8'h20);
    send_rx(9'h142, 1, 0, 0);
    rx_check("R11", 8'h31);
    rd(3'd3, r); chk("R11", "attention stays on", {24'h0, r}, 32'h30);

    chk("R8", "tx queue drained", txq_n.size(), 32'd0);
    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule